// File: doc/BRIEF.md
# Programming busy timer sequencer

This block is the target-side timer of a parallel memory-programming handshake. A host lowers an active-low write strobe to launch a self-timed programming operation. The block then holds an active-high ready/busy flag low for a duration fixed by the command class. There are three classes: a byte-type write (data memory, fuse or lock bits), a full chip erase, and a flash page write. When that duration ends the flag returns high and a one-cycle completion pulse reports which class finished.

The strobe and the output enable reach the block asynchronously, so each passes through a two-stage synchronizer. A low strobe pulse only counts once it has stayed low for a minimum number of clock cycles. That count comes from a minimum pulse width in nanoseconds and the clock frequency, so glitches are rejected. Each busy duration is set to the middle of its allowed window, in clock cycles at `CLK_HZ`. A strobe that arrives while the block is busy does not disturb the running operation. Such a strobe, or a strobe carrying the reserved class code, sets a sticky error flag. The host clears that flag by driving the output enable low while the block is ready.

Top module: `prog_busy_seq`

## Requirements
- R1: Reset drives rdy_bsy_o high and done_o and err_o low, and stops any operation that is running.
- R2: A qualified strobe pulls rdy_bsy_o low on the (2 + QUAL) rising edge that counts from the first edge to sample wr_n_i low. QUAL = max(1, ceil(WR_MIN_NS * CLK_HZ / 1e9)).
- R3: A wr_n_i low pulse shorter than QUAL cycles starts nothing: rdy_bsy_o stays high and err_o is unchanged.
- R4: Class code 2'b00 (byte-type write) holds rdy_bsy_o low for exactly floor(CLK_HZ * 1350 / 1e6) cycles.
- R5: Class code 2'b01 (chip erase) holds rdy_bsy_o low for exactly floor(CLK_HZ * 22000 / 1e6) cycles.
- R6: Class code 2'b10 (flash page write) holds rdy_bsy_o low for exactly floor(CLK_HZ * 11000 / 1e6) cycles.
- R7: A qualified strobe while rdy_bsy_o is low leaves the busy length and the class of the running operation unchanged, and sets err_o.
- R8: A qualified strobe carrying class code 2'b11 starts nothing, so rdy_bsy_o stays high, and it sets err_o.
- R9: On the edge where rdy_bsy_o returns high, done_o is high for exactly one cycle. At that point done_cls_o carries the class that was sampled on the start edge, even if cmd_cls_i changes later.
- R10: err_o stays set until oe_n_i, after its two-stage synchronizer, is low while rdy_bsy_o is high. Driving oe_n_i low while busy does not clear it.
- R11: A strobe held low for longer than an operation triggers exactly one operation and sets no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock at CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_cls_i | input | 2 | Command class: 00 byte-type, 01 chip erase, 10 flash write, 11 reserved |
| wr_n_i | input | 1 | Active-low write strobe, asynchronous |
| oe_n_i | input | 1 | Active-low output enable, asynchronous; clears the error flag while ready |
| rdy_bsy_o | output | 1 | High when ready, low while the operation runs |
| done_o | output | 1 | One-cycle completion pulse |
| done_cls_o | output | 2 | Class of the operation that just completed |
| err_o | output | 1 | Sticky error: strobe while busy or reserved class |

## Verification
The flag falls QUAL+2 edges after the strobe is first sampled low: two synchronizer stages, then the qualification count. It then stays low for the class duration, and done_o coincides with the first high cycle. The bench drives every input just after a falling edge. It samples at the next falling edges and counts them, so the latency and the busy length are measured as exact cycle counts against values computed from the formulas in the requirements. An error-flag clear through oe_n_i is due three edges after the enable goes low, and the bench waits past that before reading err_o.

// File: rtl/prog_busy_pkg.sv
package prog_busy_pkg;

    typedef enum logic [1:0] {
        CLS_BYTE  = 2'b00,
        CLS_ERASE = 2'b01,
        CLS_FLASH = 2'b10,
        CLS_RSVD  = 2'b11
    } cmd_cls_e;

    // Midpoints of the allowed busy windows, in microseconds
    localparam longint BYTE_MID_US  = 1350;
    localparam longint ERASE_MID_US = 22000;
    localparam longint FLASH_MID_US = 11000;

    function automatic longint cyc_for_us(input longint clk_hz, input longint us);
        longint c;
        c = (clk_hz * us) / 64'd1000000;
        return (c < 1) ? 64'd1 : c;
    endfunction

    function automatic longint cyc_for_ns_ceil(input longint clk_hz, input longint ns);
        longint c;
        c = (clk_hz * ns + 64'd999999999) / 64'd1000000000;
        return (c < 1) ? 64'd1 : c;
    endfunction

    function automatic longint max3(input longint a, input longint b, input longint c);
        longint m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

endpackage

// File: rtl/prog_sync.sv
module prog_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [STAGES-1:0][WIDTH-1:0] chain;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.chain[0] = async_i;
        for (int i = 1; i < STAGES; i++) begin
            st_d.chain[i] = st_q.chain[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_o = st_q.chain[STAGES-1];
endmodule

// File: rtl/prog_strobe_qual.sv
module prog_strobe_qual #(
    parameter int QUAL = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_n_s,
    output logic start_o
);
    localparam int QW = $clog2(QUAL + 1);
    localparam logic [QW-1:0] QMAX  = QW'(QUAL);
    localparam logic [QW-1:0] QFIRE = QW'(QUAL - 1);

    typedef struct packed {
        logic [QW-1:0] low_cnt;
    } qual_st_t;

    qual_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_n_s) begin
            st_d.low_cnt = '0;
        end else if (st_q.low_cnt != QMAX) begin
            st_d.low_cnt = st_q.low_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    // Fires once, on the cycle the low run reaches QUAL samples
    assign start_o = !wr_n_s && (st_q.low_cnt == QFIRE);

    assert_single_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |=> !start_o);
endmodule

// File: rtl/prog_busy_timer.sv
module prog_busy_timer
    import prog_busy_pkg::*;
#(
    parameter int CNT_W   = 21,
    parameter int T_BYTE  = 67500,
    parameter int T_ERASE = 1100000,
    parameter int T_FLASH = 550000
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     start_i,
    input  cmd_cls_e cls_i,
    output logic     busy_o,
    output logic     done_o,
    output cmd_cls_e done_cls_o
);
    localparam logic [CNT_W-1:0] LD_BYTE  = CNT_W'(T_BYTE - 1);
    localparam logic [CNT_W-1:0] LD_ERASE = CNT_W'(T_ERASE - 1);
    localparam logic [CNT_W-1:0] LD_FLASH = CNT_W'(T_FLASH - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        cmd_cls_e         cls;
        logic             done;
        cmd_cls_e         done_cls;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == '0) begin
                st_d.busy     = 1'b0;
                st_d.done     = 1'b1;
                st_d.done_cls = st_q.cls;
            end else begin
                st_d.cnt = st_q.cnt - 1'b1;
            end
        end else if (start_i && cls_i != CLS_RSVD) begin
            st_d.busy = 1'b1;
            st_d.cls  = cls_i;
            unique case (cls_i)
                CLS_ERASE: st_d.cnt = LD_ERASE;
                CLS_FLASH: st_d.cnt = LD_FLASH;
                default:   st_d.cnt = LD_BYTE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{busy: 1'b0, cnt: '0, cls: CLS_BYTE, done: 1'b0, done_cls: CLS_BYTE};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o     = st_q.busy;
    assign done_o     = st_q.done;
    assign done_cls_o = st_q.done_cls;

    assert_busy_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && st_q.cnt != '0) |=> st_q.busy);
    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> ($past(st_q.busy) && !st_q.busy));
    assert_done_cls_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.done |-> (st_q.done_cls != CLS_RSVD));
    assert_rsvd_no_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!st_q.busy && start_i && cls_i == CLS_RSVD) |=> !st_q.busy);
    assert_cls_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.busy && $past(st_q.busy)) |-> $stable(st_q.cls));
endmodule

// File: rtl/prog_busy_seq.sv
module prog_busy_seq
    import prog_busy_pkg::*;
#(
    parameter longint CLK_HZ    = 50000000,
    parameter longint WR_MIN_NS = 67
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] cmd_cls_i,
    input  logic       wr_n_i,
    input  logic       oe_n_i,
    output logic       rdy_bsy_o,
    output logic       done_o,
    output logic [1:0] done_cls_o,
    output logic       err_o
);
    localparam int QUAL    = int'(cyc_for_ns_ceil(CLK_HZ, WR_MIN_NS));
    localparam int T_BYTE  = int'(cyc_for_us(CLK_HZ, BYTE_MID_US));
    localparam int T_ERASE = int'(cyc_for_us(CLK_HZ, ERASE_MID_US));
    localparam int T_FLASH = int'(cyc_for_us(CLK_HZ, FLASH_MID_US));
    localparam int CNT_W   = $clog2(int'(max3(T_BYTE, T_ERASE, T_FLASH)) + 1);

    logic [1:0] sync_q;
    logic       wr_n_s, oe_n_s;
    logic       start;
    logic       busy;
    cmd_cls_e   cls_in, done_cls;

    assign cls_in = cmd_cls_e'(cmd_cls_i);

    prog_sync #(.WIDTH(2), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({oe_n_i, wr_n_i}),
        .sync_o  (sync_q)
    );
    assign wr_n_s = sync_q[0];
    assign oe_n_s = sync_q[1];

    prog_strobe_qual #(.QUAL(QUAL)) u_qual (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_n_s  (wr_n_s),
        .start_o (start)
    );

    prog_busy_timer #(
        .CNT_W   (CNT_W),
        .T_BYTE  (T_BYTE),
        .T_ERASE (T_ERASE),
        .T_FLASH (T_FLASH)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (start),
        .cls_i      (cls_in),
        .busy_o     (busy),
        .done_o     (done_o),
        .done_cls_o (done_cls)
    );

    typedef struct packed {
        logic err;
    } top_st_t;

    top_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (start && (busy || cls_in == CLS_RSVD)) begin
            st_d.err = 1'b1;
        end else if (!oe_n_s && !busy) begin
            st_d.err = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdy_bsy_o  = !busy;
    assign done_cls_o = done_cls;
    assign err_o      = st_q.err;

    assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (err_o && !(!oe_n_s && rdy_bsy_o)) |=> err_o);
    assert_busy_strobe_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !rdy_bsy_o) |=> err_o);
    assert_fall_needs_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rdy_bsy_o) |-> $past(start));
endmodule

// File: tb/prog_busy_seq_tb.sv
module prog_busy_seq_tb;
    localparam longint CLK_HZ    = 20000;
    localparam longint WR_MIN_NS = 150000;
    // Expected values from the requirement formulas at these parameters
    localparam int QUAL    = 3;   // ceil(150000*20000/1e9)
    localparam int LAT     = 2 + QUAL;
    localparam int T_BYTE  = 27;  // floor(20000*1350/1e6)
    localparam int T_ERASE = 440; // floor(20000*22000/1e6)
    localparam int T_FLASH = 220; // floor(20000*11000/1e6)

    typedef struct packed {
        logic [1:0] cls;
        int         len;
        logic       starts;
        int         dur;
        logic       err;
    } vec_t;

    localparam vec_t VECS [7] = '{
        '{cls: 2'b00, len: 3, starts: 1'b1, dur: T_BYTE,  err: 1'b0},
        '{cls: 2'b01, len: 5, starts: 1'b1, dur: T_ERASE, err: 1'b0},
        '{cls: 2'b10, len: 3, starts: 1'b1, dur: T_FLASH, err: 1'b0},
        '{cls: 2'b00, len: 2, starts: 1'b0, dur: 0,       err: 1'b0},
        '{cls: 2'b10, len: 1, starts: 1'b0, dur: 0,       err: 1'b0},
        '{cls: 2'b11, len: 4, starts: 1'b0, dur: 0,       err: 1'b1},
        '{cls: 2'b00, len: 8, starts: 1'b1, dur: T_BYTE,  err: 1'b0}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cmd_cls = 2'b00;
    logic       wr_n = 1'b1;
    logic       oe_n = 1'b1;
    logic       rdy, done, err;
    logic [1:0] done_cls;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    prog_busy_seq #(.CLK_HZ(CLK_HZ), .WR_MIN_NS(WR_MIN_NS)) u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_cls_i  (cmd_cls),
        .wr_n_i     (wr_n),
        .oe_n_i     (oe_n),
        .rdy_bsy_o  (rdy),
        .done_o     (done),
        .done_cls_o (done_cls),
        .err_o      (err)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clr_err();
        @(negedge clk) oe_n = 1'b0;
        repeat (4) @(negedge clk);
        oe_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // Drives one strobe and measures latency, busy length and completion
    task automatic run_op(input logic [1:0] cls, input int len,
                          output int lat, output int dur,
                          output int dseen, output int dcls, output int dafter);
        int n;
        n = 0; lat = 0; dur = 0; dseen = 0; dcls = 0; dafter = 0;
        @(negedge clk);
        cmd_cls = cls;
        wr_n = 1'b0;
        while (n < 12 && lat == 0) begin
            @(negedge clk);
            n++;
            if (n == len) wr_n = 1'b1;
            if (!rdy) lat = n;
        end
        if (lat == 0) begin
            wr_n = 1'b1;
            return;
        end
        dur = 1;
        while (dur < 2000) begin
            @(negedge clk);
            n++;
            if (n == len) wr_n = 1'b1;
            if (rdy) break;
            dur++;
        end
        dseen = int'(done);
        dcls  = int'(done_cls);
        @(negedge clk);
        dafter = int'(done);
        wr_n = 1'b1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        int lat, dur, dseen, dcls, dafter, falls;
        logic prev;
        repeat (3) @(negedge clk);
        chk("R1 rdy after reset", int'(rdy), 1);
        chk("R1 done after reset", int'(done), 0);
        chk("R1 err after reset", int'(err), 0);
        @(negedge clk) rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // Vector table walk
        foreach (VECS[i]) begin
            run_op(VECS[i].cls, VECS[i].len, lat, dur, dseen, dcls, dafter);
            repeat (4) @(negedge clk);
            if (VECS[i].starts) begin
                chk("R2 start latency", lat, LAT);
                chk("R4 R5 R6 busy length", dur, VECS[i].dur);
                chk("R9 done on rise", dseen, 1);
                chk("R9 done class", dcls, int'(VECS[i].cls));
                chk("R9 done one cycle", dafter, 0);
            end else begin
                chk("R3 R8 no start", lat, 0);
                chk("R3 R8 rdy stays high", int'(rdy), 1);
            end
            chk("R3 R8 error flag", int'(err), int'(VECS[i].err));
            if (err) clr_err();
            chk("R10 clear when ready", int'(err), 0);
        end

        // R7: strobe during a flash write
        @(negedge clk);
        cmd_cls = 2'b10;
        wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        dur = 0;
        while (dur < 2000) begin
            @(negedge clk);
            if (rdy && dur > 0) break;
            if (!rdy) dur++;
            if (dur == 20) begin wr_n = 1'b0; cmd_cls = 2'b01; end
            if (dur == 25) wr_n = 1'b1;
        end
        chk("R7 busy length unchanged", dur, T_FLASH);
        chk("R7 class unchanged", int'(done_cls), 2);
        chk("R7 error set", int'(err), 1);

        // R10: enable low while busy must not clear
        @(negedge clk);
        cmd_cls = 2'b00;
        wr_n = 1'b0;
        repeat (4) @(negedge clk);
        wr_n = 1'b1;
        repeat (4) @(negedge clk);
        chk("R10 busy for clear test", int'(rdy), 0);
        oe_n = 1'b0;
        repeat (5) @(negedge clk);
        oe_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R10 not cleared while busy", int'(err), 1);
        repeat (40) @(negedge clk);
        clr_err();
        chk("R10 cleared when ready", int'(err), 0);

        // R9: class change right after start
        @(negedge clk);
        cmd_cls = 2'b00;
        wr_n = 1'b0;
        repeat (LAT) @(negedge clk);
        cmd_cls = 2'b01;
        wr_n = 1'b1;
        dur = 1;
        while (dur < 2000) begin
            @(negedge clk);
            if (rdy) break;
            dur++;
        end
        chk("R9 latched class", int'(done_cls), 0);
        chk("R9 latched length", dur, T_BYTE);

        // R11: held strobe gives one operation
        falls = 0;
        prev = rdy;
        @(negedge clk);
        cmd_cls = 2'b00;
        wr_n = 1'b0;
        repeat (200) begin
            @(negedge clk);
            if (prev && !rdy) falls++;
            prev = rdy;
        end
        wr_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R11 single operation", falls, 1);
        chk("R11 no error", int'(err), 0);

        // R1: reset during an erase
        @(negedge clk);
        cmd_cls = 2'b01;
        wr_n = 1'b0;
        repeat (10) @(negedge clk);
        wr_n = 1'b1;
        chk("R1 busy before reset", int'(rdy), 0);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R1 rdy on reset", int'(rdy), 1);
        chk("R1 done on reset", int'(done), 0);
        rst_n = 1'b1;
        repeat (20) @(negedge clk);
        chk("R1 stays idle after reset", int'(rdy), 1);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule